// File: doc/BRIEF.md
# Snake-Order Reference Window Shifter

This block holds the reference pixels that a sum-of-absolute-differences datapath compares against one block of the current frame. The stored window is square, `BLK` × `BLK` pixels. All `BLK*BLK` pixels are presented in parallel, and each window belongs to one candidate position in a rectangular search area.

Candidates are visited in serpentine order:

- Line 0 is walked from left to right.
- At the end of a line the walk steps down one candidate.
- The next line is walked from right to left, and the direction keeps alternating.

Each step moves the stored window by one pixel. Only the one newly exposed line is fetched from on-chip memory: a column for a horizontal step, a row for a vertical step. A fresh candidate therefore costs one line fetch, not a full window reload.

The memory handshake is a single cycle. The block raises a request with a line kind and a coordinate. The memory answers in the same cycle with a valid strobe and `BLK` pixels. When data keeps arriving, one new window is produced per clock once the initial fill is complete.

Top module: `snake_ref_window`

## Requirements
- R1: After an accepted start, the block issues exactly `BLK` row fetches before the first valid window. These fetches are at x=0 with y=0,1,...,`BLK`-1 in that order. The first window presented is candidate (0,0).
- R2: Whenever `win_vld_o` is high, pixel (r,c) of `win_o` equals reference pixel (y=`cand_y_o`+r, x=`cand_x_o`+c). Pixel (r,c) sits at bit offset (r*`BLK`+c)*`PIX_W`.
- R3: Over one run the candidates appear in serpentine order and each appears once. Line y is walked with x increasing when y is even and decreasing when y is odd. The run presents `cols_i`*`rows_i` windows in total.
- R4: Every step after the fill consumes exactly one line fetch:
  - A step to x+1 fetches column (x+`BLK`, y).
  - A step to x-1 fetches column (x-1, y).
  - A step down fetches row (x, y+`BLK`).
  - `req_col_o`=1 marks a column fetch. Line pixel i lies at bit offset i*`PIX_W` and is pixel (y+i, x) for a column fetch or pixel (y, x+i) for a row fetch.
- R5: `win_vld_o` is high for exactly one cycle per new window, in the cycle after the fetch that formed it. With data always available, consecutive windows of a run come on consecutive cycles.
- R6: `done_o` rises in the cycle after the last window of a run is presented. It stays high, with no request and no valid window, until the next start.
- R7: A start pulse while a run is in progress is ignored, and the run continues unchanged.
- R8: In a cycle where a fetch is requested but `ld_vld_i` is low, nothing advances: the next cycle has no valid window, and the window and candidate outputs are unchanged.
- R9: The range sizes are sampled at start and may be any value from 1 to the maximum. A 1×1 range yields one window. A single-column range walks straight down.
- R10: During reset, `win_vld_o`, `done_o` and `req_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a run; accepted only when idle or done |
| cols_i | input | CNT_W | Number of candidate columns, 1..MAX_COLS |
| rows_i | input | CNT_H | Number of candidate rows, 1..MAX_ROWS |
| req_o | output | 1 | Line fetch requested this cycle |
| req_col_o | output | 1 | 1 = column fetch, 0 = row fetch |
| req_x_o | output | AXW | x coordinate of the first pixel of the line |
| req_y_o | output | AYW | y coordinate of the first pixel of the line |
| ld_vld_i | input | 1 | Line data valid, same cycle as the request |
| ld_data_i | input | BLK*PIX_W | Line pixels, pixel i at bits i*PIX_W |
| win_o | output | BLK*BLK*PIX_W | Window pixels, row-major |
| win_vld_o | output | 1 | Pulse: a new candidate window is presented |
| cand_x_o | output | CXW | Candidate x offset within the search area |
| cand_y_o | output | CYW | Candidate y offset within the search area |
| done_o | output | 1 | Run complete |

## Verification
The stimulus aims at the serpentine turn points:

- **Turn points.** Getting the direction flip or the edge column wrong produces windows that are offset by one pixel, or a candidate sequence that repeats or skips a line end. The scoreboard catches both.
- **Stalls.** Fetch stalls are mixed in. A design that advances without data shows a window formed from garbage, or a duplicated valid pulse.
- **Degenerate ranges.** 1×1 and single-column ranges check that the walker never issues a horizontal step when none exists, and that the done flag follows the final window at once.
- **Mid-run start.** A start pulse in the middle of a run checks that the range is not re-latched.

// File: rtl/srw_pkg.sv
package srw_pkg;

    // Which way the stored window is moved when a fetched line is accepted.
    typedef enum logic [1:0] {
        MV_NONE = 2'd0,
        MV_DOWN = 2'd1,   // rows shift up, new row enters at the bottom
        MV_EAST = 2'd2,   // columns shift left, new column enters at the right
        MV_WEST = 2'd3    // columns shift right, new column enters at the left
    } srw_move_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_RUN  = 2'd2,
        ST_DONE = 2'd3
    } srw_state_e;

endpackage

// File: rtl/srw_walker.sv
module srw_walker
    import srw_pkg::*;
#(
    parameter int BLK      = 16,
    parameter int MAX_COLS = 32,
    parameter int MAX_ROWS = 32,
    localparam int CNT_W = $clog2(MAX_COLS + 1),
    localparam int CNT_H = $clog2(MAX_ROWS + 1),
    localparam int CXW   = $clog2(MAX_COLS),
    localparam int CYW   = $clog2(MAX_ROWS),
    localparam int AXW   = $clog2(MAX_COLS + BLK),
    localparam int AYW   = $clog2(MAX_ROWS + BLK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] cols_i,
    input  logic [CNT_H-1:0] rows_i,
    output logic             req_o,
    output logic             req_col_o,
    output logic [AXW-1:0]   req_x_o,
    output logic [AYW-1:0]   req_y_o,
    input  logic             ld_vld_i,
    output srw_move_e        mv_o,
    output logic             vld_o,
    output logic [CXW-1:0]   cand_x_o,
    output logic [CYW-1:0]   cand_y_o,
    output logic             done_o
);

    localparam int FW = $clog2(BLK);

    typedef struct packed {
        srw_state_e       st;
        logic [CXW-1:0]   cx;
        logic [CYW-1:0]   cy;
        logic             west;
        logic [CNT_W-1:0] lx;
        logic [CNT_H-1:0] ly;
        logic [FW-1:0]    fill;
        logic             vld;
        logic             done;
    } walk_t;

    walk_t walk_d, walk_q;

    always_comb begin
        walk_d     = walk_q;
        walk_d.vld = 1'b0;
        req_o      = 1'b0;
        req_col_o  = 1'b0;
        req_x_o    = '0;
        req_y_o    = '0;
        mv_o       = MV_NONE;
        case (walk_q.st)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    walk_d.st   = ST_FILL;
                    walk_d.cx   = '0;
                    walk_d.cy   = '0;
                    walk_d.west = 1'b0;
                    walk_d.lx   = cols_i - CNT_W'(1);
                    walk_d.ly   = rows_i - CNT_H'(1);
                    walk_d.fill = '0;
                    walk_d.done = 1'b0;
                end
            end
            ST_FILL: begin
                req_o   = 1'b1;
                req_y_o = AYW'(walk_q.fill);
                if (ld_vld_i) begin
                    mv_o        = MV_DOWN;
                    walk_d.fill = walk_q.fill + FW'(1);
                    if (walk_q.fill == FW'(BLK - 1)) begin
                        walk_d.st  = ST_RUN;
                        walk_d.vld = 1'b1;
                    end
                end
            end
            ST_RUN: begin
                if (!walk_q.west && (CNT_W'(walk_q.cx) != walk_q.lx)) begin
                    req_o     = 1'b1;
                    req_col_o = 1'b1;
                    req_x_o   = AXW'(walk_q.cx) + AXW'(BLK);
                    req_y_o   = AYW'(walk_q.cy);
                    if (ld_vld_i) begin
                        mv_o       = MV_EAST;
                        walk_d.cx  = walk_q.cx + CXW'(1);
                        walk_d.vld = 1'b1;
                    end
                end else if (walk_q.west && (walk_q.cx != '0)) begin
                    req_o     = 1'b1;
                    req_col_o = 1'b1;
                    req_x_o   = AXW'(walk_q.cx) - AXW'(1);
                    req_y_o   = AYW'(walk_q.cy);
                    if (ld_vld_i) begin
                        mv_o       = MV_WEST;
                        walk_d.cx  = walk_q.cx - CXW'(1);
                        walk_d.vld = 1'b1;
                    end
                end else if (CNT_H'(walk_q.cy) != walk_q.ly) begin
                    req_o   = 1'b1;
                    req_x_o = AXW'(walk_q.cx);
                    req_y_o = AYW'(walk_q.cy) + AYW'(BLK);
                    if (ld_vld_i) begin
                        mv_o        = MV_DOWN;
                        walk_d.cy   = walk_q.cy + CYW'(1);
                        walk_d.west = !walk_q.west;
                        walk_d.vld  = 1'b1;
                    end
                end else begin
                    walk_d.st   = ST_DONE;
                    walk_d.done = 1'b1;
                end
            end
            default: walk_d = walk_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            walk_q <= '{st: ST_IDLE, default: '0};
        end else begin
            walk_q <= walk_d;
        end
    end

    assign vld_o    = walk_q.vld;
    assign cand_x_o = walk_q.cx;
    assign cand_y_o = walk_q.cy;
    assign done_o   = walk_q.done;

endmodule

// File: rtl/srw_shift_grid.sv
module srw_shift_grid
    import srw_pkg::*;
#(
    parameter int BLK   = 16,
    parameter int PIX_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  srw_move_e                  mv_i,
    input  logic [BLK*PIX_W-1:0]       line_i,
    output logic [BLK*BLK*PIX_W-1:0]   win_o
);

    logic [PIX_W-1:0] line  [BLK];
    logic [PIX_W-1:0] px_d  [BLK][BLK];
    logic [PIX_W-1:0] px_q  [BLK][BLK];

    for (genvar i = 0; i < BLK; i++) begin : g_line
        assign line[i] = line_i[i*PIX_W +: PIX_W];
    end

    always_comb begin
        px_d = px_q;
        case (mv_i)
            MV_DOWN: begin
                for (int r = 0; r < BLK - 1; r++) begin
                    for (int c = 0; c < BLK; c++) px_d[r][c] = px_q[r+1][c];
                end
                for (int c = 0; c < BLK; c++) px_d[BLK-1][c] = line[c];
            end
            MV_EAST: begin
                for (int r = 0; r < BLK; r++) begin
                    for (int c = 0; c < BLK - 1; c++) px_d[r][c] = px_q[r][c+1];
                    px_d[r][BLK-1] = line[r];
                end
            end
            MV_WEST: begin
                for (int r = 0; r < BLK; r++) begin
                    for (int c = 1; c < BLK; c++) px_d[r][c] = px_q[r][c-1];
                    px_d[r][0] = line[r];
                end
            end
            default: px_d = px_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            px_q <= '{default: '{default: '0}};
        end else begin
            px_q <= px_d;
        end
    end

    for (genvar r = 0; r < BLK; r++) begin : g_row
        for (genvar c = 0; c < BLK; c++) begin : g_col
            assign win_o[(r*BLK+c)*PIX_W +: PIX_W] = px_q[r][c];
        end
    end

endmodule

// File: rtl/snake_ref_window.sv
module snake_ref_window
    import srw_pkg::*;
#(
    parameter int BLK      = 16,
    parameter int PIX_W    = 8,
    parameter int MAX_COLS = 32,
    parameter int MAX_ROWS = 32,
    localparam int CNT_W = $clog2(MAX_COLS + 1),
    localparam int CNT_H = $clog2(MAX_ROWS + 1),
    localparam int CXW   = $clog2(MAX_COLS),
    localparam int CYW   = $clog2(MAX_ROWS),
    localparam int AXW   = $clog2(MAX_COLS + BLK),
    localparam int AYW   = $clog2(MAX_ROWS + BLK)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [CNT_W-1:0]         cols_i,
    input  logic [CNT_H-1:0]         rows_i,
    output logic                     req_o,
    output logic                     req_col_o,
    output logic [AXW-1:0]           req_x_o,
    output logic [AYW-1:0]           req_y_o,
    input  logic                     ld_vld_i,
    input  logic [BLK*PIX_W-1:0]     ld_data_i,
    output logic [BLK*BLK*PIX_W-1:0] win_o,
    output logic                     win_vld_o,
    output logic [CXW-1:0]           cand_x_o,
    output logic [CYW-1:0]           cand_y_o,
    output logic                     done_o
);

    srw_move_e mv;

    srw_walker #(
        .BLK      (BLK),
        .MAX_COLS (MAX_COLS),
        .MAX_ROWS (MAX_ROWS)
    ) u_walker (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .cols_i    (cols_i),
        .rows_i    (rows_i),
        .req_o     (req_o),
        .req_col_o (req_col_o),
        .req_x_o   (req_x_o),
        .req_y_o   (req_y_o),
        .ld_vld_i  (ld_vld_i),
        .mv_o      (mv),
        .vld_o     (win_vld_o),
        .cand_x_o  (cand_x_o),
        .cand_y_o  (cand_y_o),
        .done_o    (done_o)
    );

    srw_shift_grid #(
        .BLK   (BLK),
        .PIX_W (PIX_W)
    ) u_grid (
        .clk    (clk),
        .rst_n  (rst_n),
        .mv_i   (mv),
        .line_i (ld_data_i),
        .win_o  (win_o)
    );

endmodule

// File: rtl/srw_checker.sv
module srw_checker #(
    parameter int BLK      = 16,
    parameter int PIX_W    = 8,
    parameter int AXW      = 6,
    parameter int AYW      = 6,
    parameter int CXW      = 5,
    parameter int CYW      = 5
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     start_i,
    input logic                     req_o,
    input logic                     req_col_o,
    input logic [AXW-1:0]           req_x_o,
    input logic [AYW-1:0]           req_y_o,
    input logic                     ld_vld_i,
    input logic [BLK*PIX_W-1:0]     ld_data_i,
    input logic [BLK*BLK*PIX_W-1:0] win_o,
    input logic                     win_vld_o,
    input logic [CXW-1:0]           cand_x_o,
    input logic [CYW-1:0]           cand_y_o,
    input logic                     done_o
);

    // R8: a request without data leaves the window and candidate untouched
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ld_vld_i) |=> (!win_vld_o && $stable(win_o) &&
                                  $stable(cand_x_o) && $stable(cand_y_o)));

    // R5: a valid window is always the result of an accepted fetch
    p_valid_from_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        win_vld_o |-> $past(req_o && ld_vld_i));

    // R4: a column fetch sits on the current line, one step beyond an edge
    p_col_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && req_col_o) |->
            ((int'(req_y_o) == int'(cand_y_o)) &&
             ((int'(req_x_o) == int'(cand_x_o) + BLK) ||
              (int'(req_x_o) + 1 == int'(cand_x_o)))));

    // R2: an eastward step moves column 1 into column 0 and the line into the last column
    p_shift_east_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && ld_vld_i && req_col_o && (int'(req_x_o) > int'(cand_x_o))) |=>
            ((win_o[0 +: PIX_W] == $past(win_o[PIX_W +: PIX_W])) &&
             (win_o[(BLK-1)*PIX_W +: PIX_W] == $past(ld_data_i[0 +: PIX_W]))));

    // R6: once done, the block is quiet
    p_done_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!req_o && !win_vld_o));

    // R6: done persists until a start arrives
    p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

endmodule

bind snake_ref_window srw_checker #(
    .BLK   (BLK),
    .PIX_W (PIX_W),
    .AXW   (AXW),
    .AYW   (AYW),
    .CXW   (CXW),
    .CYW   (CYW)
) u_srw_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .req_o     (req_o),
    .req_col_o (req_col_o),
    .req_x_o   (req_x_o),
    .req_y_o   (req_y_o),
    .ld_vld_i  (ld_vld_i),
    .ld_data_i (ld_data_i),
    .win_o     (win_o),
    .win_vld_o (win_vld_o),
    .cand_x_o  (cand_x_o),
    .cand_y_o  (cand_y_o),
    .done_o    (done_o)
);

// File: tb/test_snake_ref_window.sv
`timescale 1ns/1ps
module test_snake_ref_window;

    localparam int BLK      = 16;
    localparam int PIX_W    = 8;
    localparam int MAX_COLS = 32;
    localparam int MAX_ROWS = 32;
    localparam int CNT_W = $clog2(MAX_COLS + 1);
    localparam int CNT_H = $clog2(MAX_ROWS + 1);
    localparam int CXW   = $clog2(MAX_COLS);
    localparam int CYW   = $clog2(MAX_ROWS);
    localparam int AXW   = $clog2(MAX_COLS + BLK);
    localparam int AYW   = $clog2(MAX_ROWS + BLK);

    typedef struct packed { int x; int y; } cand_t;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     start_i = 1'b0;
    logic [CNT_W-1:0]         cols_i = '0;
    logic [CNT_H-1:0]         rows_i = '0;
    logic                     req_o, req_col_o;
    logic [AXW-1:0]           req_x_o;
    logic [AYW-1:0]           req_y_o;
    logic                     ld_vld_i = 1'b0;
    logic [BLK*PIX_W-1:0]     ld_data_i;
    logic [BLK*BLK*PIX_W-1:0] win_o;
    logic                     win_vld_o;
    logic [CXW-1:0]           cand_x_o;
    logic [CYW-1:0]           cand_y_o;
    logic                     done_o;

    int    total = 0;
    int    bad = 0;
    int    seed = 0;
    int    cyc = 0;
    bit    stall_mode = 0;
    bit    r7_tag = 0;
    cand_t exp_q[$];
    cand_t cur;
    bit    have_cur = 0;
    bit    in_fill = 0;
    int    fill_cnt = 0;
    bit    prev_vld = 0, prev_take = 0, prev_stall = 0, done_prev = 0;
    logic [BLK*BLK*PIX_W-1:0] prev_win = '0;
    int    first_vld_cyc = 0, last_vld_cyc = 0, n_vld = 0;

    always #2.5 clk = ~clk;

    snake_ref_window #(
        .BLK(BLK), .PIX_W(PIX_W), .MAX_COLS(MAX_COLS), .MAX_ROWS(MAX_ROWS)
    ) i_snake_ref_window (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cols_i(cols_i), .rows_i(rows_i),
        .req_o(req_o), .req_col_o(req_col_o), .req_x_o(req_x_o), .req_y_o(req_y_o),
        .ld_vld_i(ld_vld_i), .ld_data_i(ld_data_i), .win_o(win_o), .win_vld_o(win_vld_o),
        .cand_x_o(cand_x_o), .cand_y_o(cand_y_o), .done_o(done_o)
    );

    function automatic logic [7:0] ref_px(int s, int y, int x);
        return 8'((x * 29) + (y * 71) + (x * y * 5) + (s * 13) + ((x ^ y) << 2));
    endfunction

    // modelled search memory, answers in the request cycle
    always_comb begin
        for (int i = 0; i < BLK; i++) begin
            if (req_col_o) ld_data_i[i*PIX_W +: PIX_W] = ref_px(seed, int'(req_y_o) + i, int'(req_x_o));
            else           ld_data_i[i*PIX_W +: PIX_W] = ref_px(seed, int'(req_y_o), int'(req_x_o) + i);
        end
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // data availability pattern
    initial begin
        forever begin
            @(posedge clk); #1;
            ld_vld_i = stall_mode ? ((cyc % 5 != 2) && (cyc % 7 != 4)) : 1'b1;
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                bad++; total++;
                $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall) begin
                check(!win_vld_o && (win_o == prev_win), "R8", "stall hold", int'(win_vld_o), 0);
            end
            if (win_vld_o) begin
                check(prev_take, "R5", "valid without a fetch", 0, 1);
                if (in_fill) begin
                    check(fill_cnt == BLK, "R1", "fill rows before first window", fill_cnt, BLK);
                    in_fill = 0;
                end
                if (exp_q.size() == 0) begin
                    check(0, "R3", "unexpected extra window", int'(cand_x_o), -1);
                end else begin
                    cand_t e;
                    int    mr, mc;
                    bit    okw;
                    e = exp_q.pop_front();
                    check((int'(cand_x_o) == e.x) && (int'(cand_y_o) == e.y),
                          r7_tag ? "R3 R7" : "R3", "candidate x*64+y",
                          int'(cand_x_o) * 64 + int'(cand_y_o), e.x * 64 + e.y);
                    okw = 1; mr = 0; mc = 0;
                    for (int r = 0; r < BLK; r++) begin
                        for (int c = 0; c < BLK; c++) begin
                            if (okw && (win_o[(r*BLK+c)*PIX_W +: PIX_W] != ref_px(seed, e.y + r, e.x + c))) begin
                                okw = 0; mr = r; mc = c;
                            end
                        end
                    end
                    check(okw, r7_tag ? "R2 R7" : "R2", "window pixel",
                          int'(win_o[(mr*BLK+mc)*PIX_W +: PIX_W]), int'(ref_px(seed, e.y + mr, e.x + mc)));
                    cur = e; have_cur = 1;
                end
                if (n_vld == 0) first_vld_cyc = cyc;
                last_vld_cyc = cyc;
                n_vld++;
            end
            if (req_o && ld_vld_i) begin
                if (in_fill) begin
                    check(!req_col_o && (req_x_o == '0) && (int'(req_y_o) == fill_cnt),
                          "R1", "fill fetch row", int'(req_y_o), fill_cnt);
                    fill_cnt++;
                end else if (have_cur && exp_q.size() != 0) begin
                    cand_t nx;
                    int ex, ey;
                    bit ecol;
                    nx = exp_q[0];
                    if (nx.y == cur.y) begin
                        ecol = 1; ey = cur.y;
                        ex = (nx.x > cur.x) ? cur.x + BLK : cur.x - 1;
                    end else begin
                        ecol = 0; ex = cur.x; ey = cur.y + BLK;
                    end
                    check((req_col_o == ecol) && (int'(req_x_o) == ex) && (int'(req_y_o) == ey),
                          "R4", "fetch address x*64+y", int'(req_x_o) * 64 + int'(req_y_o), ex * 64 + ey);
                end
            end
            if (done_o && !done_prev) begin
                check(prev_vld, "R6", "done right after last window", int'(prev_vld), 1);
            end
            prev_take  = req_o && ld_vld_i;
            prev_stall = req_o && !ld_vld_i;
            prev_vld   = win_vld_o;
            done_prev  = done_o;
            prev_win   = win_o;
        end
    end

    task automatic run_case(int cols, int rows, int s, bit stall, bit poke_start, string tag);
        int waited;
        seed = s;
        stall_mode = stall;
        in_fill = 1; fill_cnt = 0; have_cur = 0; n_vld = 0; r7_tag = 0;
        for (int y = 0; y < rows; y++) begin
            for (int k = 0; k < cols; k++) begin
                cand_t e;
                e.y = y;
                e.x = (y % 2 == 0) ? k : cols - 1 - k;
                exp_q.push_back(e);
            end
        end
        @(posedge clk); #1;
        cols_i = CNT_W'(cols); rows_i = CNT_H'(rows); start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        if (poke_start) begin
            repeat (40) @(posedge clk);
            #1;
            cols_i = CNT_W'(2); rows_i = CNT_H'(2); start_i = 1'b1;
            r7_tag = 1;
            @(posedge clk); #1;
            start_i = 1'b0;
        end
        waited = 0;
        while (!done_o && waited < 20000) begin
            @(negedge clk);
            waited++;
        end
        check(done_o, "R6", {tag, " done reached"}, int'(done_o), 1);
        check(exp_q.size() == 0, "R3", {tag, " windows left over"}, exp_q.size(), 0);
        check(n_vld == cols * rows, tag, "window count", n_vld, cols * rows);
        if (!stall) begin
            check(last_vld_cyc - first_vld_cyc == cols * rows - 1, "R5",
                  {tag, " one window per cycle"}, last_vld_cyc - first_vld_cyc, cols * rows - 1);
        end
        repeat (3) @(negedge clk);
        check(done_o && !req_o && !win_vld_o, "R6", {tag, " done holds quietly"}, int'(done_o), 1);
        exp_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!win_vld_o && !done_o && !req_o, "R10", "reset outputs quiet",
              int'({win_vld_o, done_o, req_o}), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        run_case(MAX_COLS, MAX_ROWS, 3, 0, 0, "full range");
        run_case(5, 3, 7, 1, 1, "R7 R8 stalled 5x3");
        run_case(1, 1, 11, 0, 0, "R9 1x1");
        run_case(1, 4, 5, 1, 0, "R9 one column");
        run_case(6, 2, 9, 0, 0, "6x2");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule